// File: doc/BRIEF.md
# Polling-Sequence Bus Arbiter

A centralized arbiter for a shared bus that chooses the next bus owner by polling. Every device drives its own request, and these requests are ORed into one shared request line. While that line is active and nobody holds the bus, the arbiter steps through a programmable table of device addresses, one entry per clock. It presents the current entry on the poll-count lines. Each device port compares the polled value with its own strapped address. A port that matches while its device is requesting raises busy and takes the bus, and polling freezes until the owner lets go.

A device's priority is the position of its address in the table. After the owner releases the bus, polling resumes at the entry that follows the winning one, so ownership rotates through the table. The table may be rewritten only while the bus is fully idle. A per-device fault input removes that device from arbitration, and the remaining devices are still polled and served.

Top module: `poll_arbiter`

## Requirements
- R1: `bus_req_o` is the OR of all bits of `dev_req_i`, in the same cycle.
- R2: After reset the table pointer is 0, no device is busy, and table entry k holds address k (modulo 2^ADDR_W).
- R3: `poll_valid_o` is high exactly when `bus_req_o` is high and `busy_o` is low. `poll_o` always shows the table entry at the current pointer.
- R4: If device d is requesting, not faulted, and its address equals `poll_o` while `poll_valid_o` is high, then bit d of `dev_busy_o` is set on the next clock, and `busy_o` rises with it.
- R5: At most one bit of `dev_busy_o` is set at any time.
- R6: In each cycle with `poll_valid_o` high, the pointer advances by one entry, and it wraps from entry SEQ_LEN-1 to entry 0.
- R7: While `busy_o` is high, `poll_valid_o` is low and `poll_o` does not change.
- R8: An owner keeps its busy bit while it requests. Its busy bit clears on the clock after its request falls.
- R9: After a release, polling resumes at the table entry that follows the winner's entry.
- R10: When several devices request at once, the device whose address comes first in the table, counting from the current pointer, wins first.
- R11: A table write (`seq_we_i` with index and address) takes effect on the next clock only when `bus_req_o` and `busy_o` are both low. Otherwise it is ignored.
- R12: A device with its fault input high never gains busy. A faulted owner loses busy on the next clock. Polling of the other devices continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | N_DEV | Per-device bus request |
| dev_fault_i | input | N_DEV | Per-device fault; excludes the device from arbitration |
| dev_addr_i | input | N_DEV*ADDR_W | Strapped unique address of each device, device d in bits [d*ADDR_W +: ADDR_W] |
| seq_we_i | input | 1 | Sequence table write strobe |
| seq_idx_i | input | IDX_W | Table entry to write |
| seq_addr_i | input | ADDR_W | Device address to store |
| bus_req_o | output | 1 | Shared request line |
| poll_valid_o | output | 1 | Poll-count lines carry a live poll |
| poll_o | output | ADDR_W | Poll-count lines |
| busy_o | output | 1 | Bus held by a device |
| dev_busy_o | output | N_DEV | Per-device busy; one-hot or zero |

## Verification
Two functions can meet in the same cycle: a table write and an active poll or hold. The bench issues writes while one device owns the bus, and again while another request is being polled. It then checks the polled value at the affected entries, which must show the old table contents. A second collision occurs when a fault arrives in the same cycle as an owner's hold, or when a faulted device is polled alongside a healthy requester. In those cases the bench checks that the grant moves past the faulted device to the healthy one at the expected poll step.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_POLL = 2'd1,
    ARB_HELD = 2'd2
  } arb_state_e;
endpackage

// File: rtl/poll_seq_table.sv
module poll_seq_table #(
  parameter int unsigned SEQ_LEN = 8,
  parameter int unsigned ADDR_W  = 3,
  localparam int unsigned IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_addr_o
);
  logic [ADDR_W-1:0] entry_q [SEQ_LEN];

  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        entry_q[k] <= ADDR_W'(k);
      else if (wr_en_i && (wr_idx_i == IDX_W'(k)))
        entry_q[k] <= wr_addr_i;
    end
  end

  assign rd_addr_o = entry_q[rd_idx_i];
endmodule

// File: rtl/poll_sequencer.sv
module poll_sequencer #(
  parameter int unsigned SEQ_LEN = 8,
  localparam int unsigned IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(SEQ_LEN - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  // advance on every live poll; a winner also moves past its own entry
  always_comb begin
    ptr_d = ptr_q;
    if (step_i) ptr_d = (ptr_q == LastIdx) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/poll_dev_port.sv
module poll_dev_port #(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic              poll_valid_i,
  input  logic              claim_i,
  output logic              match_o,
  output logic              busy_o
);
  logic busy_q;
  logic win;

  assign match_o = poll_valid_i && req_i && !fault_i && (addr_i == poll_addr_i);
  // claim_i resolves a misprogrammed duplicate address toward the lower port
  assign win     = match_o && !claim_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_q <= 1'b0;
    else if (busy_q) busy_q <= req_i && !fault_i;
    else             busy_q <= win;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter
  import poll_arb_pkg::*;
#(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEQ_LEN = 8,
  localparam int unsigned IDX_W  = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_DEV-1:0]        dev_req_i,
  input  logic [N_DEV-1:0]        dev_fault_i,
  input  logic [N_DEV*ADDR_W-1:0] dev_addr_i,
  input  logic                    seq_we_i,
  input  logic [IDX_W-1:0]        seq_idx_i,
  input  logic [ADDR_W-1:0]       seq_addr_i,
  output logic                    bus_req_o,
  output logic                    poll_valid_o,
  output logic [ADDR_W-1:0]       poll_o,
  output logic                    busy_o,
  output logic [N_DEV-1:0]        dev_busy_o
);
  arb_state_e        state;
  logic [IDX_W-1:0]  ptr;
  logic [ADDR_W-1:0] poll_addr;
  logic [N_DEV-1:0]  match;
  logic [N_DEV-1:0]  claim;
  logic [N_DEV-1:0]  dev_busy;
  logic              busy;
  logic              shared_req;

  assign shared_req = |dev_req_i;
  assign busy       = |dev_busy;

  always_comb begin
    if (busy)            state = ARB_HELD;
    else if (shared_req) state = ARB_POLL;
    else                 state = ARB_IDLE;
  end

  poll_seq_table #(
    .SEQ_LEN (SEQ_LEN),
    .ADDR_W  (ADDR_W)
  ) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (seq_we_i && (state == ARB_IDLE)),
    .wr_idx_i  (seq_idx_i),
    .wr_addr_i (seq_addr_i),
    .rd_idx_i  (ptr),
    .rd_addr_o (poll_addr)
  );

  poll_sequencer #(
    .SEQ_LEN (SEQ_LEN)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (state == ARB_POLL),
    .ptr_o  (ptr)
  );

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    if (d == 0) begin : g_first
      assign claim[d] = 1'b0;
    end else begin : g_rest
      assign claim[d] = |match[d-1:0];
    end

    poll_dev_port #(
      .ADDR_W (ADDR_W)
    ) i_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_i        (dev_req_i[d]),
      .fault_i      (dev_fault_i[d]),
      .addr_i       (dev_addr_i[d*ADDR_W +: ADDR_W]),
      .poll_addr_i  (poll_addr),
      .poll_valid_i (state == ARB_POLL),
      .claim_i      (claim[d]),
      .match_o      (match[d]),
      .busy_o       (dev_busy[d])
    );
  end

  assign bus_req_o    = shared_req;
  assign poll_valid_o = (state == ARB_POLL);
  assign poll_o       = poll_addr;
  assign busy_o       = busy;
  assign dev_busy_o   = dev_busy;
endmodule

// File: rtl/poll_arbiter_chk.sv
module poll_arbiter_chk #(
  parameter int unsigned N_DEV  = 4,
  parameter int unsigned ADDR_W = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_DEV-1:0]        dev_req_i,
  input logic [N_DEV-1:0]        dev_fault_i,
  input logic [N_DEV*ADDR_W-1:0] dev_addr_i,
  input logic                    bus_req_o,
  input logic                    poll_valid_o,
  input logic [ADDR_W-1:0]       poll_o,
  input logic                    busy_o,
  input logic [N_DEV-1:0]        dev_busy_o
);
  AST_REQ_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == (|dev_req_i)); // R1

  AST_POLL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_valid_o == (bus_req_o && !busy_o)); // R3

  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dev_busy_o)); // R5

  AST_BUSY_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (dev_busy_o != '0)); // R4

  AST_HOLD_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(poll_o) && !poll_valid_o)); // R7

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    AST_GRANT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(dev_busy_o[d]) |-> $past(poll_valid_o && dev_req_i[d] &&
                                     (dev_addr_i[d*ADDR_W +: ADDR_W] == poll_o))); // R4

    AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dev_busy_o[d] && !dev_req_i[d]) |=> !dev_busy_o[d]); // R8

    AST_FAULT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dev_busy_o[d] |-> $past(!dev_fault_i[d])); // R12
  end
endmodule

bind poll_arbiter poll_arbiter_chk #(
  .N_DEV  (N_DEV),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dev_req_i    (dev_req_i),
  .dev_fault_i  (dev_fault_i),
  .dev_addr_i   (dev_addr_i),
  .bus_req_o    (bus_req_o),
  .poll_valid_o (poll_valid_o),
  .poll_o       (poll_o),
  .busy_o       (busy_o),
  .dev_busy_o   (dev_busy_o)
);

// File: tb/test_poll_arbiter.sv
module test_poll_arbiter;
  localparam int N_DEV = 4;
  localparam int ADDR_W = 3;
  localparam int SEQ_LEN = 8;
  localparam int IDX_W = 3;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [N_DEV-1:0]        dev_req_i = '0;
  logic [N_DEV-1:0]        dev_fault_i = '0;
  logic [N_DEV*ADDR_W-1:0] dev_addr_i = {3'd6, 3'd5, 3'd2, 3'd1};
  logic                    seq_we_i = 1'b0;
  logic [IDX_W-1:0]        seq_idx_i = '0;
  logic [ADDR_W-1:0]       seq_addr_i = '0;
  logic                    bus_req_o, poll_valid_o, busy_o;
  logic [ADDR_W-1:0]       poll_o;
  logic [N_DEV-1:0]        dev_busy_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5ns clk_i = ~clk_i;

  poll_arbiter #(.N_DEV(N_DEV), .ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN)) i_poll_arbiter (
    .clk_i, .rst_ni, .dev_req_i, .dev_fault_i, .dev_addr_i,
    .seq_we_i, .seq_idx_i, .seq_addr_i,
    .bus_req_o, .poll_valid_o, .poll_o, .busy_o, .dev_busy_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nx();
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R2 busy after reset", busy_o, 0);
    chk("R2 dev_busy after reset", dev_busy_o, 0);
    chk("R2 poll entry 0", poll_o, 0);
    chk("R1 no request", bus_req_o, 0);
    chk("R3 no poll when idle", poll_valid_o, 0);
  endtask

  task automatic t_grant();  // pointer starts at 0
    dev_req_i = 4'b0010; #1;
    chk("R1 shared request", bus_req_o, 1);
    chk("R3 poll live", poll_valid_o, 1);
    chk("R3 poll entry", poll_o, 0);
    nx(); chk("R6 advance", poll_o, 1);
    nx(); chk("R6 advance", poll_o, 2);
    chk("R4 no grant yet", dev_busy_o, 0);
    nx(); chk("R4 grant d1", dev_busy_o, 4'b0010);
    chk("R4 busy", busy_o, 1);
    chk("R7 poll frozen valid", poll_valid_o, 0);
    chk("R7 poll value", poll_o, 3);
    nx(); chk("R7 poll held", poll_o, 3);
    chk("R8 busy held", dev_busy_o, 4'b0010);
    dev_req_i = '0;
    nx(); chk("R8 release", dev_busy_o, 0);
  endtask

  task automatic t_fault();  // pointer at 3
    dev_fault_i = 4'b0100;
    dev_req_i = 4'b1100; #1;
    chk("R2 default entry 3", poll_o, 3);
    nx(); nx();
    chk("R12 faulted polled", poll_o, 5);
    nx(); chk("R12 faulted skipped", dev_busy_o, 0);
    chk("R6 step past faulted", poll_o, 6);
    nx(); chk("R12 healthy served", dev_busy_o, 4'b1000);
    dev_req_i = 4'b0100;
    nx(); chk("R8 release d3", busy_o, 0);
    chk("R9 resume after winner", poll_o, 7);
    nx(); chk("R6 wrap", poll_o, 0);
    chk("R12 faulted never busy", dev_busy_o, 0);
    dev_req_i = '0; dev_fault_i = '0;
  endtask

  task automatic t_priority();  // pointer at 0
    dev_req_i = 4'b0110;
    nx(); nx();
    chk("R10 reach addr2", poll_o, 2);
    nx(); chk("R10 earlier entry wins", dev_busy_o, 4'b0010);
    dev_req_i = 4'b0100;
    nx(); chk("R9 resume", poll_o, 3);
    chk("R3 poll live again", poll_valid_o, 1);
    nx(); nx();
    chk("R10 reach addr5", poll_o, 5);
    nx(); chk("R10 later entry served", dev_busy_o, 4'b0100);
    dev_fault_i = 4'b0100;
    nx(); chk("R12 fault drops owner", dev_busy_o, 0);
    chk("R12 polling continues", poll_valid_o, 1);
    chk("R9 entry after winner", poll_o, 6);
    dev_req_i = '0; dev_fault_i = '0;
  endtask

  task automatic t_write();  // pointer at 6
    seq_we_i = 1; seq_idx_i = 6; seq_addr_i = 1;
    nx(); seq_we_i = 0;
    dev_req_i = 4'b0001; #1;
    chk("R11 idle write taken", poll_o, 1);
    nx(); chk("R11 rewritten entry grants d0", dev_busy_o, 4'b0001);
    seq_we_i = 1; seq_idx_i = 7; seq_addr_i = 2;
    nx(); seq_we_i = 0; dev_req_i = '0;
    nx(); chk("R8 release d0", busy_o, 0);
    dev_req_i = 4'b0010;
    seq_we_i = 1; seq_idx_i = 0; seq_addr_i = 2; #1;
    chk("R11 write while busy ignored", poll_o, 7);
    nx(); seq_we_i = 0;
    chk("R11 write while polling ignored", poll_o, 0);
    nx(); nx();
    chk("R6 reach addr2", poll_o, 2);
    nx(); chk("R4 grant after wrap", dev_busy_o, 4'b0010);
    dev_req_i = '0;
    nx(); chk("R8 final release", busy_o, 0);
  endtask

  initial begin
    repeat (3) nx();
    rst_ni = 1'b1;
    nx();
    t_reset();
    t_grant();
    t_fault();
    t_priority();
    t_write();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule